// File: doc/BRIEF.md
# Bus Address Self-Assignment Controller

This controller gives a plug-and-play node a unique 7-bit bus address while the system runs. Out of reset the node answers at a shared default address. When the host broadcasts a registration call, the node takes the bus as master. It probes candidate addresses one at a time, starting just above the default and going upward, and keeps the first candidate that no other node acknowledges. It then asks for a hello message that carries its 64-bit unique identifier and its new address, and it pulses a ready flag.

The controller does not drive bus wires. It works at transaction level against a separate two-wire bus engine. It raises a probe request with a candidate address, and the engine answers with a done strobe that carries either an ACK/NACK result or an arbitration-lost flag. When arbitration is lost, the controller waits a backoff taken from the low bits of its identifier and retries the same candidate. This lets two nodes that start together drift apart. The host can later move the node with an address-update command, and out-of-range values are refused.

Top module: `addr_claim_ctrl`

## Requirements
- R1: After reset `own_addr` is 0x11, and `probe_req`, `hello_req`, `bus_master`, `addr_ready` and `claim_fail` are all 0.
- R2: Discovery starts only when `gcall_reg` is sampled high while the node is idle or failed; `probe_req` stays low otherwise, and `gcall_reg` during discovery is ignored.
- R3: The first probe after a registration call targets 0x12; each ACK result (`probe_done`=1, `probe_ack`=1, `probe_arb_lost`=0) advances the next probe to the candidate plus one, presented in the following cycle.
- R4: A NACK result (`probe_done`=1, `probe_ack`=0, `probe_arb_lost`=0) claims the candidate: `own_addr` equals it from the next cycle.
- R5: An ACK at candidate 0x77 sets `claim_fail`, drops `bus_master` in the next cycle and leaves `own_addr` unchanged; a later registration call clears `claim_fail`.
- R6: A probe completed with `probe_arb_lost`=1 holds `probe_req` low for exactly 1 + `node_uid[3:0]` cycles and then probes the same candidate again.
- R7: After a claim, `hello_req` is high with `hello_addr` = claimed address and `hello_uid` = `node_uid`, held until `hello_done`.
- R8: `addr_ready` is high for exactly one cycle, the cycle after `hello_done` is sampled with `hello_req` high.
- R9: `upd_valid` while not discovering loads `upd_addr` into `own_addr` next cycle only if it lies within 0x08..0x77; other values, and any update during discovery, leave `own_addr` unchanged.
- R10: While a probe is outstanding, `probe_addr` is stable; `probe_req` and `hello_req` are never high together.
- R11: `bus_master` is high from the cycle after the registration call until the cycle after `hello_done` or a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_uid | input | 64 | Globally unique node identifier (constant) |
| gcall_reg | input | 1 | Registration general call observed |
| upd_valid | input | 1 | Host address-update command strobe |
| upd_addr | input | 7 | New address carried by the update command |
| probe_req | output | 1 | Request the engine to issue an addressed probe |
| probe_addr | output | 7 | Candidate address to probe |
| probe_done | input | 1 | Engine finished the current probe |
| probe_ack | input | 1 | Probe was acknowledged (address taken) |
| probe_arb_lost | input | 1 | Probe lost bus arbitration |
| hello_req | output | 1 | Request transmission of the hello message |
| hello_uid | output | 64 | Identifier carried in the hello message |
| hello_addr | output | 7 | Address carried in the hello message |
| hello_done | input | 1 | Hello message sent |
| own_addr | output | 7 | Address the node currently answers at |
| addr_ready | output | 1 | One-cycle pulse: address claimed and announced |
| claim_fail | output | 1 | No free address found |
| bus_master | output | 1 | Node is acting as bus master |

## Verification
If the candidate cursor is corrupted, it shows up within one probe as an unexpected `probe_addr`. The bench sweeps every number of occupied addresses from none up to the full range, so each step of the walk and the end of the range are compared. If the backoff counter is corrupted, the low window on `probe_req` after a lost arbitration has the wrong length, and that is seen within about sixteen cycles. If the address register or the state decode is corrupted, it shows on `own_addr`, on `hello_addr` or on the ready pulse in the cycle right after the claim or the hello completion.

// File: rtl/acl_pkg.sv
package acl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_PROBE   = 3'd1,
      ST_BACKOFF = 3'd2,
      ST_HELLO   = 3'd3,
      ST_FAIL    = 3'd4
   } acl_state_e;

endpackage

// File: rtl/acl_cursor.sv
// Candidate address walker: loads the first probe address, steps upward on
// each taken candidate, and flags the top of the usable range.
module acl_cursor #(
   parameter int                ADDR_W = 7,
   parameter logic [ADDR_W-1:0] FIRST  = 7'h12,
   parameter logic [ADDR_W-1:0] LAST   = 7'h77
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   output logic [ADDR_W-1:0] cand,
   output logic              at_last
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cand <= FIRST;
      else if (load)
         cand <= FIRST;
      else if (step && !at_last)
         cand <= cand + ADDR_W'(1);
   end

   assign at_last = (cand == LAST);

endmodule

// File: rtl/acl_backoff.sv
// Backoff timer: on start it loads a length taken from the identifier bits and
// signals expiry in the last cycle of the wait.
module acl_backoff #(
   parameter int BO_BITS = 4,
   parameter int BO_BASE = 1,
   parameter int SEED_W  = 4,
   parameter int CNT_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SEED_W-1:0] uid_lo,
   output logic              expire
);

   logic [CNT_W-1:0] seed;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (BO_BITS == 0) begin : g_fixed
         logic unused_uid;
         assign unused_uid = ^uid_lo;
         assign seed       = CNT_W'(BO_BASE);
      end else begin : g_uid
         assign seed = CNT_W'(BO_BASE) + CNT_W'(uid_lo);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= seed;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/acl_addr_reg.sv
// Own-address register: default after reset, loaded by a claim, or by a
// host update that falls inside the usable range.
module acl_addr_reg #(
   parameter int                ADDR_W  = 7,
   parameter logic [ADDR_W-1:0] DEFAULT = 7'h11,
   parameter logic [ADDR_W-1:0] LO_OK   = 7'h08,
   parameter logic [ADDR_W-1:0] HI_OK   = 7'h77
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              claim_we,
   input  logic [ADDR_W-1:0] claim_addr,
   input  logic              upd_we,
   input  logic [ADDR_W-1:0] upd_addr,
   output logic [ADDR_W-1:0] addr_q
);

   logic upd_legal;

   assign upd_legal = (upd_addr >= LO_OK) && (upd_addr <= HI_OK);

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr_q <= DEFAULT;
      else if (claim_we)
         addr_q <= claim_addr;
      else if (upd_we && upd_legal)
         addr_q <= upd_addr;
   end

endmodule

// File: rtl/addr_claim_ctrl.sv
module addr_claim_ctrl #(
   parameter int ADDR_W        = 7,
   parameter int UID_W         = 64,
   parameter int DEFAULT_ADDR  = 'h11,
   parameter int START_ADDR    = 'h12,
   parameter int LOW_RSVD_TOP  = 'h07,
   parameter int HIGH_RSVD_BOT = 'h78,
   parameter int BO_BITS       = 4,
   parameter int BO_BASE       = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [UID_W-1:0]  node_uid,
   input  logic              gcall_reg,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_addr,
   output logic              probe_req,
   output logic [ADDR_W-1:0] probe_addr,
   input  logic              probe_done,
   input  logic              probe_ack,
   input  logic              probe_arb_lost,
   output logic              hello_req,
   output logic [UID_W-1:0]  hello_uid,
   output logic [ADDR_W-1:0] hello_addr,
   input  logic              hello_done,
   output logic [ADDR_W-1:0] own_addr,
   output logic              addr_ready,
   output logic              claim_fail,
   output logic              bus_master
);
   import acl_pkg::*;

   localparam int FIRST_OK    = LOW_RSVD_TOP + 1;
   localparam int LAST_OK     = HIGH_RSVD_BOT - 1;
   localparam int PROBE_FIRST = (START_ADDR < FIRST_OK) ? FIRST_OK : START_ADDR;
   localparam int SEED_W      = (BO_BITS > 0) ? BO_BITS : 1;
   localparam int CNT_W       = $clog2(BO_BASE + (1 << BO_BITS) + 1) + 1;

   localparam logic [ADDR_W-1:0] A_DEFAULT = ADDR_W'(DEFAULT_ADDR);
   localparam logic [ADDR_W-1:0] A_FIRST   = ADDR_W'(PROBE_FIRST);
   localparam logic [ADDR_W-1:0] A_LO_OK   = ADDR_W'(FIRST_OK);
   localparam logic [ADDR_W-1:0] A_HI_OK   = ADDR_W'(LAST_OK);

   generate
      if (DEFAULT_ADDR < FIRST_OK || DEFAULT_ADDR > LAST_OK) begin : g_bad_default
         $error("default address lies in a reserved range");
      end
      if (PROBE_FIRST > LAST_OK) begin : g_bad_start
         $error("probe start lies above the usable range");
      end
      if (BO_BASE < 1) begin : g_bad_backoff
         $error("backoff base must be at least one cycle");
      end
      if (HIGH_RSVD_BOT > (1 << ADDR_W)) begin : g_bad_width
         $error("address width too small for reserved bound");
      end
      if (UID_W < SEED_W) begin : g_bad_uid
         $error("identifier narrower than backoff seed");
      end
   endgenerate

   acl_state_e state_q, state_d;

   logic              gcall_go;
   logic              res_lost;
   logic              res_taken;
   logic              res_free;
   logic              cand_last;
   logic              bo_expire;
   logic              ready_q;
   logic [ADDR_W-1:0] cand;

   assign gcall_go  = gcall_reg && (state_q == ST_IDLE || state_q == ST_FAIL);
   assign res_lost  = (state_q == ST_PROBE) && probe_done && probe_arb_lost;
   assign res_taken = (state_q == ST_PROBE) && probe_done && !probe_arb_lost && probe_ack;
   assign res_free  = (state_q == ST_PROBE) && probe_done && !probe_arb_lost && !probe_ack;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE, ST_FAIL: if (gcall_go) state_d = ST_PROBE;
         ST_PROBE: begin
            if (res_lost)        state_d = ST_BACKOFF;
            else if (res_free)   state_d = ST_HELLO;
            else if (res_taken)  state_d = cand_last ? ST_FAIL : ST_PROBE;
         end
         ST_BACKOFF: if (bo_expire)  state_d = ST_PROBE;
         ST_HELLO:   if (hello_done) state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ready_q <= 1'b0;
      end else begin
         state_q <= state_d;
         ready_q <= (state_q == ST_HELLO) && hello_done;
      end
   end

   acl_cursor #(
      .ADDR_W (ADDR_W),
      .FIRST  (A_FIRST),
      .LAST   (A_HI_OK)
   ) u_cursor (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (gcall_go),
      .step    (res_taken),
      .cand    (cand),
      .at_last (cand_last)
   );

   acl_backoff #(
      .BO_BITS (BO_BITS),
      .BO_BASE (BO_BASE),
      .SEED_W  (SEED_W),
      .CNT_W   (CNT_W)
   ) u_backoff (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (res_lost),
      .uid_lo (node_uid[SEED_W-1:0]),
      .expire (bo_expire)
   );

   acl_addr_reg #(
      .ADDR_W  (ADDR_W),
      .DEFAULT (A_DEFAULT),
      .LO_OK   (A_LO_OK),
      .HI_OK   (A_HI_OK)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .claim_we   (res_free),
      .claim_addr (cand),
      .upd_we     (upd_valid && (state_q == ST_IDLE || state_q == ST_FAIL)),
      .upd_addr   (upd_addr),
      .addr_q     (own_addr)
   );

   assign probe_req  = (state_q == ST_PROBE);
   assign probe_addr = cand;
   assign hello_req  = (state_q == ST_HELLO);
   assign hello_uid  = node_uid;
   assign hello_addr = own_addr;
   assign addr_ready = ready_q;
   assign claim_fail = (state_q == ST_FAIL);
   assign bus_master = (state_q == ST_PROBE) || (state_q == ST_BACKOFF) ||
                       (state_q == ST_HELLO);

endmodule

// File: rtl/addr_claim_ctrl_checker.sv
module addr_claim_ctrl_checker #(
   parameter int ADDR_W = 7,
   parameter int LO_OK  = 'h08,
   parameter int HI_OK  = 'h77,
   parameter int FIRST  = 'h12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              gcall_reg,
   input logic              probe_req,
   input logic [ADDR_W-1:0] probe_addr,
   input logic              probe_done,
   input logic              hello_req,
   input logic              hello_done,
   input logic [ADDR_W-1:0] own_addr,
   input logic              addr_ready,
   input logic              claim_fail,
   input logic              bus_master
);

   localparam logic [ADDR_W-1:0] C_LO    = ADDR_W'(LO_OK);
   localparam logic [ADDR_W-1:0] C_HI    = ADDR_W'(HI_OK);
   localparam logic [ADDR_W-1:0] C_FIRST = ADDR_W'(FIRST);

   p_probe_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      probe_req |-> (probe_addr >= C_FIRST) && (probe_addr <= C_HI));

   p_probe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      probe_req && !probe_done |=> probe_req && $stable(probe_addr));

   p_one_master_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(probe_req && hello_req));

   p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ready |=> !addr_ready);

   p_ready_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ready |-> $past(hello_req && hello_done));

   p_fail_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      claim_fail |-> !bus_master && !probe_req && !hello_req);

   p_addr_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (own_addr >= C_LO) && (own_addr <= C_HI));

   p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_master) |-> $past(gcall_reg));

   p_hello_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hello_req && !hello_done |=> hello_req && $stable(own_addr));

endmodule

bind addr_claim_ctrl addr_claim_ctrl_checker #(
   .ADDR_W (ADDR_W),
   .LO_OK  (LOW_RSVD_TOP + 1),
   .HI_OK  (HIGH_RSVD_BOT - 1),
   .FIRST  ((START_ADDR < LOW_RSVD_TOP + 1) ? LOW_RSVD_TOP + 1 : START_ADDR)
) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .gcall_reg  (gcall_reg),
   .probe_req  (probe_req),
   .probe_addr (probe_addr),
   .probe_done (probe_done),
   .hello_req  (hello_req),
   .hello_done (hello_done),
   .own_addr   (own_addr),
   .addr_ready (addr_ready),
   .claim_fail (claim_fail),
   .bus_master (bus_master)
);

// File: tb/addr_claim_ctrl_test.sv
module addr_claim_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] node_uid = '0;
   logic        gcall_reg = 1'b0;
   logic        upd_valid = 1'b0;
   logic [6:0]  upd_addr = '0;
   logic        probe_req;
   logic [6:0]  probe_addr;
   logic        probe_done = 1'b0;
   logic        probe_ack = 1'b0;
   logic        probe_arb_lost = 1'b0;
   logic        hello_req;
   logic [63:0] hello_uid;
   logic [6:0]  hello_addr;
   logic        hello_done = 1'b0;
   logic [6:0]  own_addr;
   logic        addr_ready;
   logic        claim_fail;
   logic        bus_master;

   int n_vec = 0;
   int n_bad = 0;
   int exp_addr = 'h11;
   bit finished = 0;

   always #5 clk = ~clk;

   addr_claim_ctrl uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .node_uid       (node_uid),
      .gcall_reg      (gcall_reg),
      .upd_valid      (upd_valid),
      .upd_addr       (upd_addr),
      .probe_req      (probe_req),
      .probe_addr     (probe_addr),
      .probe_done     (probe_done),
      .probe_ack      (probe_ack),
      .probe_arb_lost (probe_arb_lost),
      .hello_req      (hello_req),
      .hello_uid      (hello_uid),
      .hello_addr     (hello_addr),
      .hello_done     (hello_done),
      .own_addr       (own_addr),
      .addr_ready     (addr_ready),
      .claim_fail     (claim_fail),
      .bus_master     (bus_master)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic host_update(input logic [6:0] a);
      upd_valid = 1'b1;
      upd_addr  = a;
      @(posedge clk);
      @(negedge clk);
      upd_valid = 1'b0;
      if (a >= 7'h08 && a <= 7'h77) exp_addr = a;
      chk("R9 host update", own_addr, exp_addr);
   endtask

   // k = number of occupied addresses starting at 0x12; arb = inject one lost arbitration
   task automatic run_disc(input int k, input bit arb, input logic [63:0] uid);
      int  cand;
      bit  arb_done;
      bit  fin;
      bit  lost;
      bit  taken;
      int  lowcnt;
      node_uid  = uid;
      gcall_reg = 1'b1;
      @(posedge clk);
      @(negedge clk);
      gcall_reg = 1'b0;
      chk("R11 bus_master after call", bus_master, 1);
      chk("R5 fail cleared by call", claim_fail, 0);
      cand = 'h12;
      arb_done = 0;
      fin = 0;
      while (!fin) begin
         chk("R3 probe_req", probe_req, 1);
         chk("R3 probe_addr", probe_addr, cand);
         lost  = arb && !arb_done && (cand == 'h12 + k / 2);
         taken = (cand < 'h12 + k);
         probe_done     = 1'b1;
         probe_ack      = taken;
         probe_arb_lost = lost;
         if (arb) begin
            gcall_reg = 1'b1;        // R2: ignored while discovering
            upd_valid = 1'b1;        // R9: ignored while discovering
            upd_addr  = 7'h30;
         end
         @(posedge clk);
         @(negedge clk);
         probe_done = 1'b0; probe_ack = 1'b0; probe_arb_lost = 1'b0;
         gcall_reg  = 1'b0; upd_valid = 1'b0;
         if (lost) begin
            arb_done = 1;
            lowcnt = 0;
            while (!probe_req && lowcnt < 100) begin
               lowcnt++;
               @(negedge clk);
            end
            chk("R6 backoff length", lowcnt, 1 + (uid & 64'hF));
         end else if (taken) begin
            if (cand == 'h77) begin
               chk("R5 claim_fail", claim_fail, 1);
               chk("R5 bus_master off", bus_master, 0);
               chk("R5 addr unchanged", own_addr, exp_addr);
               fin = 1;
            end else begin
               cand++;
            end
         end else begin
            exp_addr = cand;
            chk("R4 claimed addr", own_addr, cand);
            chk("R7 hello_req", hello_req, 1);
            chk("R7 hello_addr", hello_addr, cand);
            chk("R7 hello_uid", hello_uid, uid);
            chk("R10 no probe during hello", probe_req, 0);
            repeat (2) @(negedge clk);
            chk("R7 hello held", hello_req, 1);
            chk("R8 no early ready", addr_ready, 0);
            hello_done = 1'b1;
            @(posedge clk);
            @(negedge clk);
            hello_done = 1'b0;
            chk("R8 ready pulse", addr_ready, 1);
            chk("R7 hello released", hello_req, 0);
            chk("R11 bus_master released", bus_master, 0);
            @(negedge clk);
            chk("R8 ready single cycle", addr_ready, 0);
            chk("R4 addr kept", own_addr, exp_addr);
            fin = 1;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 own_addr default", own_addr, 'h11);
      chk("R1 probe_req", probe_req, 0);
      chk("R1 hello_req", hello_req, 0);
      chk("R1 bus_master", bus_master, 0);
      chk("R1 addr_ready", addr_ready, 0);
      chk("R1 claim_fail", claim_fail, 0);

      repeat (5) @(negedge clk);
      chk("R2 idle without call", probe_req, 0);

      host_update(7'h40);
      host_update(7'h05);
      host_update(7'h7B);
      host_update(7'h08);

      for (int k = 0; k <= 102; k++)
         run_disc(k, (k % 4) == 1, 64'h5EED_0000_0000_0000 | 64'(k * 37));

      run_disc(3, 1'b1, 64'h0123_4567_89AB_CDEF);

      host_update(7'h77);
      host_update(7'h78);
      host_update(7'h00);

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule